// File: doc/BRIEF.md
# Predicated Element Byte-Enable Sequencer

This block drives the write side of a vector loop over a 64-bit-wide register file. It receives a start pulse together with a loop description: a vector length, a sub-vector code, an element-width code, a predicate source kind and a 3-bit mask selector. It then issues one step per clock. Each step names the element and sub-element being written, the register offset from the vector base, the byte offset inside that register, and an 8-bit byte write-enable for the write port.

Element positions are numbered from the least significant end. Elements pack upward through the bytes of one register and then continue into the next register. The predicate for each element comes from one of two places. In integer mode it is a bit of one of three 64-bit mask words, a complement of such a bit, or an equality test against the first word. In condition mode it is one flag of a 4-bit condition field, taken from a supplied field vector starting at a fixed base field. A false predicate still uses its step but enables no bytes.

Top module: `pred_byte_sequencer`

## Requirements
- R1: After reset, busy and done are 0 and byteEn is 8'h00. Whenever busy is 0, byteEn is 8'h00.
- R2: A start pulse with vl > 0 while idle makes busy 1 from the next cycle for exactly vl×(subvlCode+1) cycles. done is 1 for exactly one cycle, the cycle after the last step, and busy is 0 in that cycle.
- R3: A start pulse with vl = 0 issues no step: busy stays 0 and byteEn stays 0. done pulses for one cycle in the cycle after start.
- R4: Width code ewCode sets the bytes per element: 00 is 8 bytes, 01 is 4, 10 is 2 and 11 is 1. For step k (counted from 0), the byte position is p = k×bytes, regOffset = p/8 and byteOffset = p mod 8.
- R5: When the predicate is true, byteEn has `bytes` consecutive ones starting at bit byteOffset. For 64-bit elements this is 8'hFF, and for 8-bit elements it is a single bit.
- R6: When the predicate is false, the step still takes its cycle and advances the position, and byteEn is 8'h00.
- R7: With predMode = 0, the predicate of element i is chosen by maskSel: 000 is always true; 001 is true when the full 64-bit maskR3 equals i; 010 and 011 are bit i of maskR3 set and clear; 100 and 101 are the same for maskR10; 110 and 111 are the same for maskR30.
- R8: With predMode = 1, element i tests condition field 32+i, located at crFields[4(32+i)+3 : 4(32+i)]. Within a field, bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO. maskSel[2:1] selects LT, GT, EQ or SO in that order, and maskSel[0] = 1 tests for the flag being clear.
- R9: subvlCode values 00 to 11 give 1 to 4 sub-elements per element. subIdx counts 0 up to subvlCode before elemIdx increments. Every sub-element uses the predicate of its element.
- R10: A start pulse while busy is ignored: the current loop keeps its step count and position sequence.
- R11: vl, subvlCode, ewCode, predMode and maskSel are captured at start. Changing them during a loop has no effect on that loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a loop |
| vl | input | 7 | Vector length, 0 to 64 |
| subvlCode | input | 2 | Sub-elements per element minus one |
| ewCode | input | 2 | Element width code |
| predMode | input | 1 | Predicate source: 0 is integer masks, 1 is condition fields |
| maskSel | input | 3 | Predicate selector |
| maskR3 | input | 64 | First integer mask word |
| maskR10 | input | 64 | Second integer mask word |
| maskR30 | input | 64 | Third integer mask word |
| crFields | input | 512 | 128 condition fields of 4 bits; field j is at bits 4j+3:4j |
| busy | output | 1 | A step is being issued this cycle |
| done | output | 1 | One-cycle pulse that marks the end of a loop |
| elemIdx | output | 6 | Element index of the current step |
| subIdx | output | 2 | Sub-element index of the current step |
| regOffset | output | 8 | Register offset from the vector base |
| byteOffset | output | 3 | Byte position of the element within its register |
| byteEn | output | 8 | Byte write-enable for the 64-bit write port |

## Verification
The hardest case to reach is a long loop that runs into the top of every counter at once. This means 64 elements of four sub-elements each at full width, so that regOffset reaches 255. It also means condition fields near the end of the supplied vector. The stimulus table contains two 256-step loops, one at byte width with a dense irregular mask and one at double-word width. The other rows walk all sixteen predicate codes, including an equality mask whose upper 32 bits are nonzero and so must match no element. One directed run raises start again in the middle of a loop and changes every captured setting at the same time. The bench then confirms that the step sequence still follows the original settings.

// File: rtl/pbes_pkg.sv
package pbes_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  // strobes sent from control to datapath
  typedef struct packed {
    logic load;   // capture configuration, clear position
    logic step;   // advance to the next sub-element
  } seqStrobe_t;

  // byte count of one element for a width code
  function automatic logic [3:0] widthBytes(input logic [1:0] code);
    case (code)
      2'b00:   widthBytes = 4'd8;
      2'b01:   widthBytes = 4'd4;
      2'b10:   widthBytes = 4'd2;
      default: widthBytes = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/pbes_pred.sv
module pbes_pred #(
  parameter int ELEM_W   = 6,
  parameter int MASK_W   = 64,
  parameter int CR_COUNT = 128,
  parameter int CR_BASE  = 32
) (
  input  logic [ELEM_W-1:0]     elemIdx,
  input  logic                  predMode,
  input  logic [2:0]            maskSel,
  input  logic [MASK_W-1:0]     maskR3,
  input  logic [MASK_W-1:0]     maskR10,
  input  logic [MASK_W-1:0]     maskR30,
  input  logic [CR_COUNT*4-1:0] crFields,
  output logic                  predBit
);

  localparam int CR_IDX_W = $clog2(CR_COUNT);

  logic [MASK_W-1:0]   srcWord;
  logic                intBit;
  logic [CR_IDX_W-1:0] crIdx;
  logic [3:0]          crField;
  logic                crBit;

  always_comb begin
    case (maskSel[2:1])
      2'b00, 2'b01: srcWord = maskR3;
      2'b10:        srcWord = maskR10;
      default:      srcWord = maskR30;
    endcase
    if (maskSel == 3'b000)      intBit = 1'b1;
    else if (maskSel == 3'b001) intBit = (maskR3 == MASK_W'(elemIdx));
    else                        intBit = srcWord[elemIdx] ^ maskSel[0];
  end

  always_comb begin
    crIdx   = CR_IDX_W'(CR_BASE) + CR_IDX_W'(elemIdx);
    crField = crFields[{crIdx, 2'b00} +: 4];
    crBit   = crField[2'd3 - maskSel[2:1]] ^ maskSel[0];
  end

  assign predBit = predMode ? crBit : intBit;

endmodule

// File: rtl/pbes_ctrl.sv
module pbes_ctrl
  import pbes_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       vlZero,
  input  logic       isLast,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  seqState_t state, stateNext;
  logic      doneNext;

  always_comb begin
    stateNext   = state;
    doneNext    = 1'b0;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          if (vlZero) doneNext  = 1'b1;
          else        stateNext = ST_RUN;
        end
      end
      default: begin
        strobe.step = 1'b1;
        if (isLast) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/pbes_datapath.sv
module pbes_datapath
  import pbes_pkg::*;
#(
  parameter int VL_W     = 7,
  parameter int ELEM_W   = 6,
  parameter int POS_W    = 11,
  parameter int MASK_W   = 64,
  parameter int CR_COUNT = 128,
  parameter int CR_BASE  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic                  busy,
  input  logic [VL_W-1:0]       vl,
  input  logic [1:0]            subvlCode,
  input  logic [1:0]            ewCode,
  input  logic                  predMode,
  input  logic [2:0]            maskSel,
  input  logic [MASK_W-1:0]     maskR3,
  input  logic [MASK_W-1:0]     maskR10,
  input  logic [MASK_W-1:0]     maskR30,
  input  logic [CR_COUNT*4-1:0] crFields,
  output logic                  isLast,
  output logic [ELEM_W-1:0]     elemIdx,
  output logic [1:0]            subIdx,
  output logic [POS_W-4:0]      regOffset,
  output logic [2:0]            byteOffset,
  output logic [7:0]            byteEn
);

  logic [VL_W-1:0]  cfgVl;
  logic [1:0]       cfgSub;
  logic [1:0]       cfgEw;
  logic             cfgMode;
  logic [2:0]       cfgSel;
  logic [POS_W-1:0] bytePos;
  logic [3:0]       elemBytes;
  logic             subLast;
  logic             predBit;
  logic [8:0]       laneMask;

  assign elemBytes = widthBytes(cfgEw);
  assign subLast   = (subIdx == cfgSub);
  assign isLast    = subLast && (VL_W'(elemIdx) == cfgVl - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgVl   <= '0;
      cfgSub  <= '0;
      cfgEw   <= '0;
      cfgMode <= 1'b0;
      cfgSel  <= '0;
      elemIdx <= '0;
      subIdx  <= '0;
      bytePos <= '0;
    end else if (strobe.load) begin
      cfgVl   <= vl;
      cfgSub  <= subvlCode;
      cfgEw   <= ewCode;
      cfgMode <= predMode;
      cfgSel  <= maskSel;
      elemIdx <= '0;
      subIdx  <= '0;
      bytePos <= '0;
    end else if (strobe.step) begin
      bytePos <= bytePos + POS_W'(elemBytes);
      if (subLast) begin
        subIdx  <= '0;
        elemIdx <= elemIdx + 1'b1;
      end else begin
        subIdx  <= subIdx + 1'b1;
      end
    end
  end

  pbes_pred #(
    .ELEM_W  (ELEM_W),
    .MASK_W  (MASK_W),
    .CR_COUNT(CR_COUNT),
    .CR_BASE (CR_BASE)
  ) uPred (
    .elemIdx (elemIdx),
    .predMode(cfgMode),
    .maskSel (cfgSel),
    .maskR3  (maskR3),
    .maskR10 (maskR10),
    .maskR30 (maskR30),
    .crFields(crFields),
    .predBit (predBit)
  );

  assign regOffset  = bytePos[POS_W-1:3];
  assign byteOffset = bytePos[2:0];
  assign laneMask   = (9'd1 << elemBytes) - 9'd1;
  assign byteEn     = (busy && predBit) ? (laneMask[7:0] << byteOffset) : 8'h00;

endmodule

// File: rtl/pred_byte_sequencer.sv
module pred_byte_sequencer
  import pbes_pkg::*;
#(
  parameter int MAX_VL   = 64,
  parameter int MASK_W   = 64,
  parameter int CR_COUNT = 128,
  parameter int CR_BASE  = 32,
  localparam int VL_W    = $clog2(MAX_VL + 1),
  localparam int ELEM_W  = $clog2(MAX_VL),
  localparam int POS_W   = $clog2(MAX_VL * 4 * 8)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [VL_W-1:0]       vl,
  input  logic [1:0]            subvlCode,
  input  logic [1:0]            ewCode,
  input  logic                  predMode,
  input  logic [2:0]            maskSel,
  input  logic [MASK_W-1:0]     maskR3,
  input  logic [MASK_W-1:0]     maskR10,
  input  logic [MASK_W-1:0]     maskR30,
  input  logic [CR_COUNT*4-1:0] crFields,
  output logic                  busy,
  output logic                  done,
  output logic [ELEM_W-1:0]     elemIdx,
  output logic [1:0]            subIdx,
  output logic [POS_W-4:0]      regOffset,
  output logic [2:0]            byteOffset,
  output logic [7:0]            byteEn
);

  seqStrobe_t strobe;
  logic       isLast;

  pbes_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .vlZero(vl == '0),
    .isLast(isLast),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  pbes_datapath #(
    .VL_W    (VL_W),
    .ELEM_W  (ELEM_W),
    .POS_W   (POS_W),
    .MASK_W  (MASK_W),
    .CR_COUNT(CR_COUNT),
    .CR_BASE (CR_BASE)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .vl        (vl),
    .subvlCode (subvlCode),
    .ewCode    (ewCode),
    .predMode  (predMode),
    .maskSel   (maskSel),
    .maskR3    (maskR3),
    .maskR10   (maskR10),
    .maskR30   (maskR30),
    .crFields  (crFields),
    .isLast    (isLast),
    .elemIdx   (elemIdx),
    .subIdx    (subIdx),
    .regOffset (regOffset),
    .byteOffset(byteOffset),
    .byteEn    (byteEn)
  );

endmodule

// File: rtl/pred_byte_sequencer_checker.sv
module pred_byte_sequencer_checker #(
  parameter int ELEM_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [ELEM_W-1:0] elemIdx,
  input logic [1:0]        subIdx,
  input logic [2:0]        byteOffset,
  input logic [7:0]        byteEn
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> byteEn == 8'h00);

  assert_done_ends_loop_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_no_lane_below_offset_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (byteEn & ((8'd1 << byteOffset) - 8'd1)) == 8'h00);

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(byteEn) == 0 || $countones(byteEn) == 1 ||
              $countones(byteEn) == 2 || $countones(byteEn) == 4 ||
              $countones(byteEn) == 8));

  assert_step_advances_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> !($stable(elemIdx) && $stable(subIdx)));

endmodule

bind pred_byte_sequencer pred_byte_sequencer_checker #(.ELEM_W(ELEM_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .elemIdx   (elemIdx),
  .subIdx    (subIdx),
  .byteOffset(byteOffset),
  .byteEn    (byteEn)
);

// File: tb/tb_pred_byte_sequencer.sv
module tb_pred_byte_sequencer;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [6:0]   vl = '0;
  logic [1:0]   subvlCode = '0;
  logic [1:0]   ewCode = '0;
  logic         predMode = 1'b0;
  logic [2:0]   maskSel = '0;
  logic [63:0]  maskR3 = '0;
  logic [63:0]  maskR10 = '0;
  logic [63:0]  maskR30 = '0;
  logic [511:0] crFields = '0;
  logic         busy, done;
  logic [5:0]   elemIdx;
  logic [1:0]   subIdx;
  logic [7:0]   regOffset;
  logic [2:0]   byteOffset;
  logic [7:0]   byteEn;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pred_byte_sequencer dut (
    .clk(clk), .rstN(rstN), .start(start), .vl(vl), .subvlCode(subvlCode),
    .ewCode(ewCode), .predMode(predMode), .maskSel(maskSel), .maskR3(maskR3),
    .maskR10(maskR10), .maskR30(maskR30), .crFields(crFields), .busy(busy),
    .done(done), .elemIdx(elemIdx), .subIdx(subIdx), .regOffset(regOffset),
    .byteOffset(byteOffset), .byteEn(byteEn)
  );

  typedef struct packed {
    logic [6:0]  vl;
    logic [1:0]  sub;
    logic [1:0]  ew;
    logic        mode;
    logic [2:0]  sel;
    logic [63:0] r3;
    logic [63:0] r10;
    logic [63:0] r30;
    logic [8:0]  steps;
  } caseRec_t;

  localparam int NCASE = 22;
  localparam caseRec_t CASES [NCASE] = '{
    '{7'd3,  2'd0, 2'd0, 1'b0, 3'd0, 64'h0, 64'h0, 64'h0, 9'd3},
    '{7'd8,  2'd0, 2'd3, 1'b0, 3'd0, 64'h0, 64'h0, 64'h0, 9'd8},
    '{7'd5,  2'd0, 2'd2, 1'b0, 3'd2, 64'h16, 64'h0, 64'h0, 9'd5},
    '{7'd6,  2'd0, 2'd1, 1'b0, 3'd3, 64'h16, 64'h0, 64'h0, 9'd6},
    '{7'd10, 2'd0, 2'd3, 1'b0, 3'd4, 64'h0, 64'h2A5, 64'h0, 9'd10},
    '{7'd7,  2'd0, 2'd2, 1'b0, 3'd5, 64'h0, 64'h2A5, 64'h0, 9'd7},
    '{7'd9,  2'd0, 2'd1, 1'b0, 3'd6, 64'h0, 64'h0, 64'h14B, 9'd9},
    '{7'd4,  2'd0, 2'd0, 1'b0, 3'd7, 64'h0, 64'h0, 64'h9, 9'd4},
    '{7'd8,  2'd0, 2'd3, 1'b0, 3'd1, 64'h5, 64'h0, 64'h0, 9'd8},
    '{7'd8,  2'd0, 2'd3, 1'b0, 3'd1, 64'h1_0000_0005, 64'h0, 64'h0, 9'd8},
    '{7'd3,  2'd3, 2'd2, 1'b0, 3'd2, 64'h5, 64'h0, 64'h0, 9'd12},
    '{7'd4,  2'd2, 2'd3, 1'b1, 3'd0, 64'h0, 64'h0, 64'h0, 9'd12},
    '{7'd5,  2'd0, 2'd2, 1'b1, 3'd1, 64'h0, 64'h0, 64'h0, 9'd5},
    '{7'd6,  2'd1, 2'd3, 1'b1, 3'd2, 64'h0, 64'h0, 64'h0, 9'd12},
    '{7'd6,  2'd0, 2'd1, 1'b1, 3'd3, 64'h0, 64'h0, 64'h0, 9'd6},
    '{7'd7,  2'd0, 2'd3, 1'b1, 3'd4, 64'h0, 64'h0, 64'h0, 9'd7},
    '{7'd7,  2'd0, 2'd2, 1'b1, 3'd5, 64'h0, 64'h0, 64'h0, 9'd7},
    '{7'd8,  2'd0, 2'd3, 1'b1, 3'd6, 64'h0, 64'h0, 64'h0, 9'd8},
    '{7'd8,  2'd0, 2'd0, 1'b1, 3'd7, 64'h0, 64'h0, 64'h0, 9'd8},
    '{7'd64, 2'd3, 2'd3, 1'b0, 3'd2, 64'hF0F0_1234_8001_00FF, 64'h0, 64'h0, 9'd256},
    '{7'd64, 2'd3, 2'd0, 1'b1, 3'd5, 64'h0, 64'h0, 64'h0, 9'd256},
    '{7'd1,  2'd0, 2'd0, 1'b1, 3'd7, 64'h0, 64'h0, 64'h0, 9'd1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit modelPred(input caseRec_t c, input int e);
    logic [63:0] w;
    logic [3:0]  f;
    if (c.mode == 1'b0) begin
      if (c.sel == 3'd0) return 1'b1;
      if (c.sel == 3'd1) return c.r3 == 64'(e);
      w = (c.sel[2:1] == 2'd1) ? c.r3 : (c.sel[2:1] == 2'd2) ? c.r10 : c.r30;
      return w[e] ^ c.sel[0];
    end
    f = crFields[(32 + e) * 4 +: 4];
    case (c.sel[2:1])
      2'd0: return f[3] ^ c.sel[0];
      2'd1: return f[2] ^ c.sel[0];
      2'd2: return f[1] ^ c.sel[0];
      default: return f[0] ^ c.sel[0];
    endcase
  endfunction

  // R2 R4 R5 R6 R7 R8 R9 checked per step; glitch covers R10 and R11
  task automatic runCase(input caseRec_t c, input bit glitch);
    int s, bytes, e, sb, pos;
    logic [7:0] expEn;
    logic [8:0] laneM;
    s = int'(c.sub) + 1;
    bytes = 8 >> c.ew;
    maskR3 = c.r3; maskR10 = c.r10; maskR30 = c.r30;
    vl = c.vl; subvlCode = c.sub; ewCode = c.ew; predMode = c.mode; maskSel = c.sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < int'(c.steps); k++) begin
      e = k / s; sb = k % s; pos = k * bytes;
      laneM = (9'd1 << bytes) - 9'd1;
      expEn = modelPred(c, e) ? 8'(laneM[7:0] << (pos % 8)) : 8'h00;
      check({busy, elemIdx, subIdx, regOffset, byteOffset, byteEn} ==
            {1'b1, 6'(e), 2'(sb), 8'(pos / 8), 3'(pos % 8), expEn},
            glitch ? "R10 R11" : "R4 R5 R6 R7 R8 R9", "step fields",
            64'({busy, elemIdx, subIdx, regOffset, byteOffset, byteEn}),
            64'({1'b1, 6'(e), 2'(sb), 8'(pos / 8), 3'(pos % 8), expEn}));
      if (glitch && k == 1) begin
        start = 1'b1; vl = 7'd2; ewCode = ~c.ew; maskSel = ~c.sel;
        subvlCode = ~c.sub; predMode = ~c.mode;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(!busy && done, "R2", "end of loop busy/done", {busy, done}, 2'b01);
    @(negedge clk);
    check(!busy && !done, "R2", "done one cycle", {busy, done}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int j = 0; j < 128; j++) crFields[j * 4 +: 4] = 4'((j * 7 + 3) % 16);
    repeat (3) @(negedge clk);
    check(!busy && !done && byteEn == 8'h00, "R1", "reset outputs",
          {busy, done, byteEn}, 10'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && byteEn == 8'h00, "R1", "idle after reset",
          {busy, done, byteEn}, 10'h0);

    // R3: zero-length loop
    vl = 7'd0; ewCode = 2'd0; maskSel = 3'd0; predMode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && done && byteEn == 8'h00, "R3", "vl zero done pulse",
          {busy, done, byteEn}, {1'b0, 1'b1, 8'h00});
    @(negedge clk);
    check(!busy && !done && byteEn == 8'h00, "R3", "vl zero no steps",
          {busy, done, byteEn}, 10'h0);

    for (int i = 0; i < NCASE; i++) runCase(CASES[i], 1'b0);

    // R10 R11: restart attempt and input changes mid-loop
    runCase('{7'd5, 2'd1, 2'd1, 1'b0, 3'd2, 64'h1B, 64'h0, 64'h0, 9'd10}, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule